// File: doc/BRIEF.md
# Password-Gated Write-Protection Unlock Sequencer

This block sits beside a protected non-volatile memory and watches the stream of bus writes aimed at it. It recognises one fixed six-write command that carries a user selection and two 32-bit passwords. When every write of the command lands in the expected order and both passwords equal the stored keywords of the chosen user, the write protection for that user's sectors is lifted. Erase and program logic elsewhere then sees the matching bit of `wr_allow` high.

Two users are supported, each with its own pair of keywords, supplied as static inputs. A wrong password raises a sticky protection error. That error also locks the sequencer, so only a hardware or software reset permits a new attempt. A resume pulse puts protection back for both users. A third, one-time-programmable area can be named in the command but is always refused. Active read protection on a user's sectors prevents the unlock even when the passwords are right.

Top module: `unlock_seq`

## Requirements
- R1: A command is six accepted writes, in this order (address upper half always A000h, only the data low byte checked unless stated): A000_5554h/AAh, A000_AAA8h/55h, A000_553Ch/user, A000_AAA8h/first password, A000_AAA8h/second password, A000_5558h/05h. A write with any other upper address half never advances the sequence.
- R2: In the third write, data low byte 00h selects user 0 and 01h selects user 1. Data bits 31:8 of writes 1, 2, 3 and 6 are ignored.
- R3: When both passwords equal the selected user's first and second keywords (full 32 bits), the sixth write sets bit `unlock[user]`, visible one clock after that write. Only one user bit can rise per command.
- R4: If either password differs from its keyword, the sixth write sets `prot_err` one clock later, and no unlock bit is set. Unlock bits that are already set stay set.
- R5: While `prot_err` is high, every write is ignored, so a correct command unlocks nothing. `prot_err` stays high until `rst_n` is low or `sw_rst` is high.
- R6: A `resume` pulse clears both unlock bits at the next clock. If it coincides with a successful sixth write, no unlock bit is set.
- R7: A third-write user byte of 02h (the one-time-programmable area) aborts the command. The writes that follow complete nothing, and no password comparison or error results.
- R8: If `rd_prot[user]` is high at the sixth write, the unlock bit is not set and no error is raised. `wr_allow[u]` is `unlock[u]` masked by `rd_prot[u]`.
- R9: A write that does not fit the current step returns the sequencer to idle without an error. The same write is then taken as a first write if it fits that pattern.
- R10: `sw_rst` high at a clock clears the unlock bits, the error and the sequencer, exactly as `rst_n` does.
- R11: Clocks with `wr_en` low leave the sequencer where it is, so a command may have idle gaps between its writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| wr_en | input | 1 | Bus write strobe for this cycle |
| wr_addr | input | 32 | Write address |
| wr_data | input | 32 | Write data |
| key0_a | input | 32 | User 0 first keyword |
| key0_b | input | 32 | User 0 second keyword |
| key1_a | input | 32 | User 1 first keyword |
| key1_b | input | 32 | User 1 second keyword |
| rd_prot | input | 2 | Per-user active read protection |
| resume | input | 1 | Restore write protection for both users |
| unlock | output | 2 | Per-user temporary unlock flags |
| prot_err | output | 1 | Sticky password failure / lockout flag |
| wr_allow | output | 2 | Per-user write/erase permission |

## Verification
A wrong step count or a stale stored user would show up at the ports only when a command finishes, one clock after the sixth write. It would appear as an unlock bit on the wrong user, a missing unlock, or a spurious error. A password result that is not stored correctly between the fourth and sixth writes shows the same way. The bench therefore ends most commands with a port check and also compares every output against a behavioural model on every clock. That catches a lost lockout or a missed resume within one cycle.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    // Number of command writes already accepted.
    typedef enum logic [2:0] {
        STEP_IDLE = 3'd0,
        STEP_1    = 3'd1,
        STEP_2    = 3'd2,
        STEP_3    = 3'd3,
        STEP_4    = 3'd4,
        STEP_5    = 3'd5
    } step_e;

    localparam int unsigned N_USERS = 2;

    typedef struct packed {
        step_e                step;
        logic                 user;
        logic                 pw_ok;
        logic [N_USERS-1:0]   unlock;
        logic                 err;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{
        step:   STEP_IDLE,
        user:   1'b0,
        pw_ok:  1'b0,
        unlock: '0,
        err:    1'b0
    };

endpackage

// File: rtl/unlock_step_match.sv
module unlock_step_match
    import unlock_pkg::*;
#(
    parameter int unsigned   LO_W      = 16,
    parameter logic [LO_W-1:0] ADDR_HI   = 16'hA000,
    parameter logic [LO_W-1:0] LO_FIRST  = 16'h5554,
    parameter logic [LO_W-1:0] LO_SECOND = 16'hAAA8,
    parameter logic [LO_W-1:0] LO_USER   = 16'h553C,
    parameter logic [LO_W-1:0] LO_LAST   = 16'h5558,
    parameter logic [7:0]      BYTE_1    = 8'hAA,
    parameter logic [7:0]      BYTE_2    = 8'h55,
    parameter logic [7:0]      BYTE_END  = 8'h05,
    parameter int unsigned     NUM_USERS = 2
) (
    input  step_e             step,
    input  logic [2*LO_W-1:0] addr,
    input  logic [7:0]        data_lo,
    output logic              step_hit,
    output logic              start_hit
);

    logic [LO_W-1:0] addr_hi;
    logic [LO_W-1:0] addr_lo;
    logic            hi_ok;
    logic            user_ok;

    assign addr_hi = addr[2*LO_W-1:LO_W];
    assign addr_lo = addr[LO_W-1:0];
    assign hi_ok   = (addr_hi == ADDR_HI);
    // Only user codes below NUM_USERS are legal; the OTP code is not.
    assign user_ok = ({24'd0, data_lo} < NUM_USERS);

    assign start_hit = hi_ok && (addr_lo == LO_FIRST) && (data_lo == BYTE_1);

    always_comb begin
        step_hit = 1'b0;
        unique case (step)
            STEP_IDLE: step_hit = start_hit;
            STEP_1:    step_hit = hi_ok && (addr_lo == LO_SECOND) && (data_lo == BYTE_2);
            STEP_2:    step_hit = hi_ok && (addr_lo == LO_USER) && user_ok;
            STEP_3,
            STEP_4:    step_hit = hi_ok && (addr_lo == LO_SECOND);
            STEP_5:    step_hit = hi_ok && (addr_lo == LO_LAST) && (data_lo == BYTE_END);
            default:   step_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/unlock_key_cmp.sv
module unlock_key_cmp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned USERS  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] key_a [USERS],
    input  logic [DATA_W-1:0] key_b [USERS],
    input  logic              user,
    input  logic              second,
    output logic              match
);

    logic [USERS-1:0] eq_a;
    logic [USERS-1:0] eq_b;

    for (genvar u = 0; u < USERS; u++) begin : g_user
        assign eq_a[u] = (data == key_a[u]);
        assign eq_b[u] = (data == key_b[u]);
    end

    assign match = second ? eq_b[user] : eq_a[user];

endmodule

// File: rtl/unlock_grant.sv
module unlock_grant #(
    parameter int unsigned USERS = 2
) (
    input  logic [USERS-1:0] unlock,
    input  logic [USERS-1:0] rd_prot,
    output logic [USERS-1:0] wr_allow
);

    for (genvar u = 0; u < USERS; u++) begin : g_allow
        assign wr_allow[u] = unlock[u] & ~rd_prot[u];
    end

endmodule

// File: rtl/unlock_seq.sv
module unlock_seq
    import unlock_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] key0_a,
    input  logic [DATA_W-1:0] key0_b,
    input  logic [DATA_W-1:0] key1_a,
    input  logic [DATA_W-1:0] key1_b,
    input  logic [1:0]        rd_prot,
    input  logic              resume,
    output logic [1:0]        unlock,
    output logic              prot_err,
    output logic [1:0]        wr_allow
);

    localparam int unsigned LO_W = ADDR_W / 2;

    seq_state_t st_d, st_q;

    logic              step_hit;
    logic              start_hit;
    logic              key_eq;
    logic [DATA_W-1:0] key_a_arr [N_USERS];
    logic [DATA_W-1:0] key_b_arr [N_USERS];

    assign key_a_arr[0] = key0_a;
    assign key_a_arr[1] = key1_a;
    assign key_b_arr[0] = key0_b;
    assign key_b_arr[1] = key1_b;

    unlock_step_match #(
        .LO_W      (LO_W),
        .NUM_USERS (N_USERS)
    ) u_match (
        .step      (st_q.step),
        .addr      (wr_addr),
        .data_lo   (wr_data[7:0]),
        .step_hit  (step_hit),
        .start_hit (start_hit)
    );

    unlock_key_cmp #(
        .DATA_W (DATA_W),
        .USERS  (N_USERS)
    ) u_key (
        .data   (wr_data),
        .key_a  (key_a_arr),
        .key_b  (key_b_arr),
        .user   (st_q.user),
        .second (st_q.step == STEP_4),
        .match  (key_eq)
    );

    always_comb begin
        st_d = st_q;
        if (resume) begin
            st_d.unlock = '0;
        end
        if (wr_en && !st_q.err) begin
            if (step_hit) begin
                unique case (st_q.step)
                    STEP_IDLE: st_d.step = STEP_1;
                    STEP_1:    st_d.step = STEP_2;
                    STEP_2: begin
                        st_d.user = wr_data[0];
                        st_d.step = STEP_3;
                    end
                    STEP_3: begin
                        st_d.pw_ok = key_eq;
                        st_d.step  = STEP_4;
                    end
                    STEP_4: begin
                        st_d.pw_ok = st_q.pw_ok & key_eq;
                        st_d.step  = STEP_5;
                    end
                    STEP_5: begin
                        st_d.step = STEP_IDLE;
                        if (!st_q.pw_ok) begin
                            st_d.err = 1'b1;
                        end else if (!rd_prot[st_q.user] && !resume) begin
                            st_d.unlock[st_q.user] = 1'b1;
                        end
                    end
                    default: st_d.step = STEP_IDLE;
                endcase
            end else begin
                st_d.step = start_hit ? STEP_1 : STEP_IDLE;
            end
        end
        if (sw_rst) begin
            st_d = SEQ_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlock   = st_q.unlock;
    assign prot_err = st_q.err;

    unlock_grant #(
        .USERS (N_USERS)
    ) u_grant (
        .unlock   (st_q.unlock),
        .rd_prot  (rd_prot),
        .wr_allow (wr_allow)
    );

endmodule

// File: rtl/unlock_seq_chk.sv
module unlock_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_rst,
    input logic       resume,
    input logic [1:0] rd_prot,
    input logic [1:0] unlock,
    input logic       prot_err,
    input logic [1:0] wr_allow
);

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_err && !sw_rst) |=> prot_err);

    a_r5_no_unlock_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> ((unlock & ~$past(unlock)) == 2'b00));

    a_r6_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (unlock == 2'b00));

    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (unlock == 2'b00 && !prot_err));

    a_r3_one_user_per_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unlock & ~$past(unlock)));

    a_r8_rdprot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((unlock & ~$past(unlock) & $past(rd_prot)) == 2'b00));

    a_r8_allow_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_allow & ~unlock) == 2'b00) && ((wr_allow & rd_prot) == 2'b00));

endmodule

bind unlock_seq unlock_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .resume   (resume),
    .rd_prot  (rd_prot),
    .unlock   (unlock),
    .prot_err (prot_err),
    .wr_allow (wr_allow)
);

// File: tb/unlock_seq_tb.sv
`timescale 1ns/1ps
module unlock_seq_tb;

    localparam logic [31:0] K0A = 32'h1234_5678;
    localparam logic [31:0] K0B = 32'h9ABC_DEF0;
    localparam logic [31:0] K1A = 32'h0F0F_1111;
    localparam logic [31:0] K1B = 32'hCAFE_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_prot = '0;
    logic        resume = 1'b0;
    logic [1:0]  unlock;
    logic        prot_err;
    logic [1:0]  wr_allow;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    unlock_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .key0_a(K0A), .key0_b(K0B), .key1_a(K1A), .key1_b(K1B),
        .rd_prot(rd_prot), .resume(resume),
        .unlock(unlock), .prot_err(prot_err), .wr_allow(wr_allow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    int       m_step;
    int       m_user;
    bit       m_ok;
    bit [1:0] m_unl;
    bit       m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step = 0; m_user = 0; m_ok = 0; m_unl = 0; m_err = 0;
        end else if (sw_rst) begin
            m_step = 0; m_user = 0; m_ok = 0; m_unl = 0; m_err = 0;
        end else begin
            bit [1:0] nu;
            bit       hi, first;
            int       b;
            nu = resume ? 2'b00 : m_unl;
            if (wr_en && !m_err) begin
                hi    = (wr_addr[31:16] == 16'hA000);
                b     = wr_data[7:0];
                first = hi && wr_addr[15:0] == 16'h5554 && b == 'hAA;
                if (m_step == 1 && hi && wr_addr[15:0] == 16'hAAA8 && b == 'h55)
                    m_step = 2;
                else if (m_step == 2 && hi && wr_addr[15:0] == 16'h553C && b < 2) begin
                    m_user = b; m_step = 3;
                end else if (m_step == 3 && hi && wr_addr[15:0] == 16'hAAA8) begin
                    m_ok = (wr_data == (m_user == 1 ? K1A : K0A)); m_step = 4;
                end else if (m_step == 4 && hi && wr_addr[15:0] == 16'hAAA8) begin
                    m_ok = m_ok && (wr_data == (m_user == 1 ? K1B : K0B)); m_step = 5;
                end else if (m_step == 5 && hi && wr_addr[15:0] == 16'h5558 && b == 'h05) begin
                    m_step = 0;
                    if (!m_ok) m_err = 1;
                    else if (!rd_prot[m_user] && !resume) nu[m_user] = 1'b1;
                end else
                    m_step = first ? 1 : 0;
            end
            m_unl = nu;
        end
    end

    always @(negedge clk) begin
        #5;
        check("R3 model unlock", {30'd0, unlock}, {30'd0, m_unl});
        check("R4 model prot_err", {31'd0, prot_err}, {31'd0, m_err});
        check("R8 model wr_allow", {30'd0, wr_allow}, {30'd0, m_unl & ~rd_prot});
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [31:0] usr, input logic [31:0] p1, input logic [31:0] p2);
        wr(32'hA000_5554, 32'h0000_00AA);
        wr(32'hA000_AAA8, 32'h0000_0055);
        wr(32'hA000_553C, usr);
        wr(32'hA000_AAA8, p1);
        wr(32'hA000_AAA8, p2);
        wr(32'hA000_5558, 32'h0000_0005);
    endtask

    task automatic do_resume();
        resume = 1'b1; @(negedge clk); resume = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        #1;
        check("R10 reset unlock", {30'd0, unlock}, 32'd0);
        check("R10 reset err", {31'd0, prot_err}, 32'd0);

        // R3: user 0 correct
        cmd(32'h0, K0A, K0B); #1;
        check("R3 user0 unlock", {30'd0, unlock}, 32'd1);
        check("R8 user0 allow", {30'd0, wr_allow}, 32'd1);

        // R2 / R11: user 1 with junk upper data bits and idle gaps
        wr(32'hA000_5554, 32'hDEAD_BEAA); idle(3);
        wr(32'hA000_AAA8, 32'h1234_0055); idle(1);
        wr(32'hA000_553C, 32'hFFFF_FF01); idle(2);
        wr(32'hA000_AAA8, K1A);
        wr(32'hA000_AAA8, K1B); idle(4);
        wr(32'hA000_5558, 32'hABCD_EF05); #1;
        check("R2 user1 unlock with gaps", {30'd0, unlock}, 32'd3);

        // R6 resume
        do_resume(); #1;
        check("R6 resume clears", {30'd0, unlock}, 32'd0);

        // R7 OTP area select
        cmd(32'h2, K0A, K0B); #1;
        check("R7 otp unlock", {30'd0, unlock}, 32'd0);
        check("R7 otp no err", {31'd0, prot_err}, 32'd0);

        // R1 wrong upper half on last write
        wr(32'hA000_5554, 32'hAA); wr(32'hA000_AAA8, 32'h55); wr(32'hA000_553C, 32'h0);
        wr(32'hA000_AAA8, K0A); wr(32'hA000_AAA8, K0B); wr(32'hB000_5558, 32'h05); #1;
        check("R1 bad upper address", {30'd0, unlock}, 32'd0);

        // R9 repeated first write restarts, then completes
        wr(32'hA000_5554, 32'hAA);
        cmd(32'h0, K0A, K0B); #1;
        check("R9 restart unlock", {30'd0, unlock}, 32'd1);
        check("R9 no err", {31'd0, prot_err}, 32'd0);

        // R8 read protection
        rd_prot = 2'b11;
        cmd(32'h1, K1A, K1B); #1;
        check("R8 rdprot blocks user1", {30'd0, unlock}, 32'd1);
        check("R8 allow masked", {30'd0, wr_allow}, 32'd0);
        rd_prot = 2'b00;
        do_resume();

        // R4 wrong first password
        cmd(32'h0, K0A ^ 32'h1, K0B); #1;
        check("R4 pw1 err", {31'd0, prot_err}, 32'd1);
        check("R4 pw1 no unlock", {30'd0, unlock}, 32'd0);

        // R5 lockout holds
        cmd(32'h0, K0A, K0B); idle(2); #1;
        check("R5 lockout unlock", {30'd0, unlock}, 32'd0);
        check("R5 lockout err", {31'd0, prot_err}, 32'd1);

        // R10 soft reset clears lockout
        sw_rst = 1'b1; @(negedge clk); sw_rst = 1'b0; #1;
        check("R10 soft reset err", {31'd0, prot_err}, 32'd0);

        // R4 wrong second password keeps earlier unlock
        cmd(32'h0, K0A, K0B);
        cmd(32'h1, K1A, K1B ^ 32'h8000_0000); #1;
        check("R4 pw2 err", {31'd0, prot_err}, 32'd1);
        check("R4 pw2 keeps user0", {30'd0, unlock}, 32'd1);

        // R5 hardware reset clears lockout
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; #1;
        check("R5 hw reset err", {31'd0, prot_err}, 32'd0);
        check("R5 hw reset unlock", {30'd0, unlock}, 32'd0);
        @(negedge clk);
        cmd(32'h1, K1A, K1B); #1;
        check("R5 accepted after reset", {30'd0, unlock}, 32'd2);

        idle(3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule